// File: doc/BRIEF.md
# Segment-to-Linear Address Translator

This block turns a two-part logical address, a 16-bit segment (or selector) plus an offset, into a flat linear address. A per-request mode input picks between two paths. The real-mode path scales the segment by sixteen and adds a 16-bit offset, all within a 1 MB window. The protected-mode path treats the segment as a selector into a descriptor table and reads the descriptor over a synchronous memory port. It adds the descriptor base to a 32-bit offset and checks the offset against the descriptor limit.

A requester presents a request while `req_ready` is high. A real-mode result appears one cycle later. A protected-mode result appears after two descriptor reads. Each result is either a `done` pulse with `lin_addr` or a `fault` pulse when the offset lies beyond the segment limit. Two table-base inputs, one for the global table and one for the local table, supply the table origins. The block does not check privilege and does not cache descriptors.

Top module: `addr_xlate_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `done`, `fault` and `mem_rd_en` are low, `req_ready` is high and `lin_addr` is zero. A reset during a protected fetch abandons it, and no result follows.
- R2: A real-mode request (`req_prot`=0) accepted at a clock edge gives `done`=1 and `lin_addr` = (segment × 16 + offset[15:0]) right after that edge. Offset bits 31:16 are ignored, and no descriptor read is issued.
- R3: The real-mode sum is kept to 20 bits: a carry out of bit 19 is dropped and `lin_addr[31:20]` is zero (FFFF:0010 gives 00000).
- R4: In protected mode, selector bit 2 picks the local table base (1) or the global table base (0). Bits 15:3 are the entry index, bits 1:0 are ignored, and the descriptor address is table base + index × 8.
- R5: A protected request accepted at edge E0 issues reads in the next two cycles, at the descriptor address and then at descriptor address + 4. Read data is returned one cycle after each read, and no further read is issued.
- R6: Descriptor word 0 is the 32-bit segment base. In word 1, bits 23:0 are the limit and bits 31:24 are access information, which the block ignores.
- R7: A protected translation that passes the limit gives `done`=1 and `lin_addr` = (base + offset) mod 2^32 right after the third edge following acceptance. `done` stays low before that.
- R8: A protected offset greater than the limit gives a one-cycle `fault` with `done` low and `lin_addr` zero. An offset equal to the limit is accepted.
- R9: `req_ready` is low from acceptance of a protected request until its result is issued. A `req_valid` seen during that time is ignored and gives no result.
- R10: `done` and `fault` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_prot | input | 1 | 1 = protected mode, 0 = real mode |
| req_seg | input | 16 | Real-mode segment or protected-mode selector |
| req_off | input | 32 | Offset (real mode uses bits 15:0) |
| gtab_base | input | 32 | Global descriptor table base |
| ltab_base | input | 32 | Local descriptor table base |
| mem_rd_en | output | 1 | Descriptor memory read strobe |
| mem_addr | output | 32 | Descriptor memory byte address |
| mem_rdata | input | 32 | Descriptor read data, one cycle after the strobe |
| done | output | 1 | Translation complete pulse |
| fault | output | 1 | Limit violation pulse |
| lin_addr | output | 32 | Linear address result |

## Verification
A real-mode result is due just after the edge that accepts the request. A protected result is due three edges later, and the two descriptor reads show on the port in the first and second cycles after acceptance. The bench drives inputs on falling edges and samples on falling edges. It counts edges from acceptance: it checks the read strobe and addresses after the first and second edges, checks that `done` is still low after the second edge, and checks the result after the third. Directed cases hold `req_valid` high during a fetch and assert reset mid-fetch, then check the cycle after the expected result to confirm that nothing extra follows.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
   typedef enum logic [1:0] {
      XS_IDLE = 2'd0,
      XS_RD0  = 2'd1,
      XS_RD1  = 2'd2,
      XS_CHK  = 2'd3
   } xlate_state_e;
endpackage

// File: rtl/xlate_real.sv
module xlate_real #(
   parameter int SEG_W     = 16,
   parameter int REAL_W    = 20,
   parameter int AW        = 32,
   parameter bit REAL_WRAP = 1'b1
) (
   input  logic [SEG_W-1:0] seg,
   input  logic [SEG_W-1:0] off,
   output logic [AW-1:0]    lin
);
   localparam int SHIFT = REAL_W - SEG_W;

   logic [REAL_W:0] sum;
   assign sum = {1'b0, seg, {SHIFT{1'b0}}} + (REAL_W+1)'(off);

   generate
      if (REAL_WRAP) begin : g_wrap
         logic unused_carry;
         assign unused_carry = sum[REAL_W];
         assign lin = AW'(sum[REAL_W-1:0]);
      end else begin : g_carry
         assign lin = AW'(sum);
      end
   endgenerate
endmodule

// File: rtl/xlate_sel_decode.sv
module xlate_sel_decode #(
   parameter int SEG_W    = 16,
   parameter int AW       = 32,
   parameter int TSEL_BIT = 2,
   parameter int IDX_LSB  = 3
) (
   input  logic [SEG_W-1:0] sel,
   input  logic [AW-1:0]    gbase,
   input  logic [AW-1:0]    lbase,
   output logic [AW-1:0]    desc_addr
);
   logic [SEG_W-1:0] idx_bytes;
   logic [AW-1:0]    tbase;
   logic             unused_low;

   assign idx_bytes  = {sel[SEG_W-1:IDX_LSB], {IDX_LSB{1'b0}}};
   assign tbase      = sel[TSEL_BIT] ? lbase : gbase;
   assign desc_addr  = tbase + AW'(idx_bytes);
   assign unused_low = ^sel[IDX_LSB-1:0];
endmodule

// File: rtl/xlate_fetch.sv
module xlate_fetch
   import xlate_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] desc_addr,
   input  logic [AW-1:0] off_in,
   input  logic [AW-1:0] mem_rdata,
   output logic          mem_rd_en,
   output logic [AW-1:0] mem_addr,
   output logic          busy,
   output logic          chk_en,
   output logic [AW-1:0] base_q,
   output logic [AW-1:0] off_q
);
   localparam int WORD_BYTES = AW / 8;

   xlate_state_e  state_q;
   logic [AW-1:0] desc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= XS_IDLE;
         desc_q  <= '0;
         off_q   <= '0;
         base_q  <= '0;
      end else begin
         unique case (state_q)
            XS_IDLE: if (start) begin
               desc_q  <= desc_addr;
               off_q   <= off_in;
               state_q <= XS_RD0;
            end
            XS_RD0:  state_q <= XS_RD1;
            XS_RD1: begin
               base_q  <= mem_rdata;
               state_q <= XS_CHK;
            end
            XS_CHK:  state_q <= XS_IDLE;
            default: state_q <= XS_IDLE;
         endcase
      end
   end

   assign mem_rd_en = (state_q == XS_RD0) || (state_q == XS_RD1);
   assign mem_addr  = (state_q == XS_RD1) ? desc_q + AW'(WORD_BYTES) : desc_q;
   assign busy      = (state_q != XS_IDLE);
   assign chk_en    = (state_q == XS_CHK);
endmodule

// File: rtl/xlate_limit.sv
module xlate_limit #(
   parameter int AW    = 32,
   parameter int LIM_W = 24
) (
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] off,
   input  logic [AW-1:0] word1,
   output logic [AW-1:0] lin,
   output logic          over
);
   logic [LIM_W-1:0] limit;

   assign limit = word1[LIM_W-1:0];
   assign over  = off > AW'(limit);
   assign lin   = base + off;

   generate
      if (LIM_W < AW) begin : g_acc
         logic unused_access;
         assign unused_access = ^word1[AW-1:LIM_W];
      end
   endgenerate
endmodule

// File: rtl/addr_xlate_unit.sv
module addr_xlate_unit #(
   parameter int AW        = 32,
   parameter int SEG_W     = 16,
   parameter int REAL_W    = 20,
   parameter int LIM_W     = 24,
   parameter bit REAL_WRAP = 1'b1,
   parameter int TSEL_BIT  = 2,
   parameter int IDX_LSB   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic             req_prot,
   input  logic [SEG_W-1:0] req_seg,
   input  logic [AW-1:0]    req_off,
   input  logic [AW-1:0]    gtab_base,
   input  logic [AW-1:0]    ltab_base,
   output logic             mem_rd_en,
   output logic [AW-1:0]    mem_addr,
   input  logic [AW-1:0]    mem_rdata,
   output logic             done,
   output logic             fault,
   output logic [AW-1:0]    lin_addr
);
   generate
      if (REAL_W <= SEG_W)       begin : g_bad_real  $error("REAL_W must exceed SEG_W"); end
      if (REAL_W + 1 > AW)       begin : g_bad_aw    $error("AW too narrow for real path"); end
      if (LIM_W > AW)            begin : g_bad_lim   $error("LIM_W exceeds AW"); end
      if (TSEL_BIT >= IDX_LSB)   begin : g_bad_tsel  $error("TSEL_BIT must lie below IDX_LSB"); end
      if (IDX_LSB >= SEG_W)      begin : g_bad_idx   $error("IDX_LSB out of range"); end
      if (AW % 8 != 0)           begin : g_bad_bytes $error("AW must be whole bytes"); end
   endgenerate

   logic          accept, busy, chk_en, over;
   logic [AW-1:0] real_lin, desc_addr, base_q, off_q, prot_lin;

   assign req_ready = !busy;
   assign accept    = req_valid && req_ready;

   xlate_real #(.SEG_W(SEG_W), .REAL_W(REAL_W), .AW(AW), .REAL_WRAP(REAL_WRAP)) u_real (
      .seg (req_seg),
      .off (req_off[SEG_W-1:0]),
      .lin (real_lin)
   );

   xlate_sel_decode #(.SEG_W(SEG_W), .AW(AW), .TSEL_BIT(TSEL_BIT), .IDX_LSB(IDX_LSB)) u_dec (
      .sel       (req_seg),
      .gbase     (gtab_base),
      .lbase     (ltab_base),
      .desc_addr (desc_addr)
   );

   xlate_fetch #(.AW(AW)) u_fetch (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (accept && req_prot),
      .desc_addr (desc_addr),
      .off_in    (req_off),
      .mem_rdata (mem_rdata),
      .mem_rd_en (mem_rd_en),
      .mem_addr  (mem_addr),
      .busy      (busy),
      .chk_en    (chk_en),
      .base_q    (base_q),
      .off_q     (off_q)
   );

   xlate_limit #(.AW(AW), .LIM_W(LIM_W)) u_lim (
      .base  (base_q),
      .off   (off_q),
      .word1 (mem_rdata),
      .lin   (prot_lin),
      .over  (over)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done     <= 1'b0;
         fault    <= 1'b0;
         lin_addr <= '0;
      end else begin
         done  <= 1'b0;
         fault <= 1'b0;
         if (accept && !req_prot) begin
            done     <= 1'b1;
            lin_addr <= real_lin;
         end else if (chk_en) begin
            if (over) begin
               fault    <= 1'b1;
               lin_addr <= '0;
            end else begin
               done     <= 1'b1;
               lin_addr <= prot_lin;
            end
         end
      end
   end
endmodule

// File: rtl/xlate_chk.sv
module xlate_chk #(
   parameter int AW     = 32,
   parameter int REAL_W = 20
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_ready,
   input logic          req_prot,
   input logic          mem_rd_en,
   input logic [AW-1:0] mem_addr,
   input logic          done,
   input logic          fault,
   input logic [AW-1:0] lin_addr
);
   assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!done && !fault && !mem_rd_en && req_ready));

   assert_real_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !req_prot) |=> (done && !fault));

   assert_real_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !req_prot) |=> (lin_addr[AW-1:REAL_W] == '0));

   assert_fetch_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_prot) |=> (mem_rd_en && !req_ready));

   assert_word_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en && $past(mem_rd_en)) |-> (mem_addr == $past(mem_addr) + AW'(4)));

   assert_two_reads_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en && $past(mem_rd_en)) |=> !mem_rd_en);

   assert_fault_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (lin_addr == '0));

   assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> !req_ready);

   assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && fault));

   assert_fault_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> !fault);
endmodule

bind addr_xlate_unit xlate_chk #(.AW(AW), .REAL_W(REAL_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_prot  (req_prot),
   .mem_rd_en (mem_rd_en),
   .mem_addr  (mem_addr),
   .done      (done),
   .fault     (fault),
   .lin_addr  (lin_addr)
);

// File: tb/sim_addr_xlate_unit.sv
`timescale 1ns/1ps
module sim_addr_xlate_unit;
   localparam logic [31:0] GB = 32'h0000_0000;
   localparam logic [31:0] LB = 32'h0000_0200;
   localparam int NV = 13;
   // {prot, seg, off, exp_fault, exp_lin}
   localparam logic [81:0] VEC [NV] = '{
      {1'b0, 16'h08F1, 32'h0000_0100, 1'b0, 32'h0000_9010},  // R2
      {1'b0, 16'h028F, 32'h0000_0030, 1'b0, 32'h0000_2920},  // R2
      {1'b0, 16'h1234, 32'hABCD_0005, 1'b0, 32'h0001_2345},  // R2 upper offset ignored
      {1'b0, 16'hFFFF, 32'h0000_0010, 1'b0, 32'h0000_0000},  // R3 wrap
      {1'b0, 16'hF000, 32'h0000_FFFF, 1'b0, 32'h000F_FFFF},  // R3 top of window
      {1'b1, 16'h0008, 32'h0000_01B6, 1'b0, 32'h0001_A1B6},  // R7 global
      {1'b1, 16'h0010, 32'h0000_0100, 1'b0, 32'h0002_A100},  // R8 equal to limit
      {1'b1, 16'h0010, 32'h0000_0101, 1'b1, 32'h0000_0000},  // R8 over limit
      {1'b1, 16'h0018, 32'h0000_003A, 1'b0, 32'h001A_003A},  // R6 access ignored
      {1'b1, 16'h0004, 32'h0000_02FF, 1'b0, 32'h0000_32FF},  // R4 local entry 0
      {1'b1, 16'h000C, 32'h0000_0010, 1'b0, 32'hFFFF_F010},  // R4 local entry 1
      {1'b1, 16'h000F, 32'h0000_1000, 1'b0, 32'h0000_0000},  // R4 low bits ignored, R7 wrap
      {1'b1, 16'h000C, 32'h0000_1001, 1'b1, 32'h0000_0000}   // R8 over limit
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_prot = 1'b0;
   logic [15:0] req_seg = '0;
   logic [31:0] req_off = '0;
   logic        req_ready, mem_rd_en, done, fault;
   logic [31:0] mem_addr, lin_addr;
   logic [31:0] mem_rdata = '0;
   logic [31:0] mem [256];
   int          n_chk = 0;
   int          n_fail = 0;

   always #4 clk = ~clk;

   addr_xlate_unit u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_prot(req_prot), .req_seg(req_seg), .req_off(req_off),
      .gtab_base(GB), .ltab_base(LB), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
      .mem_rdata(mem_rdata), .done(done), .fault(fault), .lin_addr(lin_addr)
   );

   always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr[9:2]];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run_req(input logic prot, input logic [15:0] seg, input logic [31:0] off,
                          input logic exp_f, input logic [31:0] exp_lin);
      logic [31:0] daddr;
      daddr = (seg[2] ? LB : GB) + {16'h0, seg[15:3], 3'b000};
      @(negedge clk);
      req_valid = 1'b1; req_prot = prot; req_seg = seg; req_off = off;
      @(negedge clk);
      req_valid = 1'b0;
      if (!prot) begin
         chk("R2 real done", {31'h0, done}, 32'd1);
         chk("R2 real fault", {31'h0, fault}, 32'd0);
         chk("R2/R3 real lin_addr", lin_addr, exp_lin);
         chk("R5 no read in real mode", {31'h0, mem_rd_en}, 32'd0);
      end else begin
         chk("R9 ready low while busy", {31'h0, req_ready}, 32'd0);
         chk("R5 first read strobe", {31'h0, mem_rd_en}, 32'd1);
         chk("R4 descriptor address", mem_addr, daddr);
         @(negedge clk);
         chk("R5 second read address", mem_addr, daddr + 32'd4);
         @(negedge clk);
         chk("R7 done not early", {31'h0, done}, 32'd0);
         chk("R5 no third read", {31'h0, mem_rd_en}, 32'd0);
         @(negedge clk);
         chk("R7/R8 done", {31'h0, done}, {31'h0, !exp_f});
         chk("R8 fault", {31'h0, fault}, {31'h0, exp_f});
         chk("R7/R8 lin_addr", lin_addr, exp_lin);
      end
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 32'h0;
      mem[2]   = 32'h0001_A000; mem[3]   = 32'h9200_FFFF;
      mem[4]   = 32'h0002_A000; mem[5]   = 32'h9200_0100;
      mem[6]   = 32'h001A_0000; mem[7]   = 32'h93FF_FFFF;
      mem[128] = 32'h0000_3000; mem[129] = 32'h8200_02FF;
      mem[130] = 32'hFFFF_F000; mem[131] = 32'hF200_1000;
   end

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset done", {31'h0, done}, 32'd0);
      chk("R1 reset ready", {31'h0, req_ready}, 32'd1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after reset fault", {31'h0, fault}, 32'd0);
      chk("R1 after reset rd_en", {31'h0, mem_rd_en}, 32'd0);
      chk("R1 after reset lin_addr", lin_addr, 32'h0);

      for (int v = 0; v < NV; v++)
         run_req(VEC[v][81], VEC[v][80:65], VEC[v][64:33], VEC[v][32], VEC[v][31:0]);

      // R9: hold a real request during a protected fetch
      @(negedge clk);
      req_valid = 1'b1; req_prot = 1'b1; req_seg = 16'h0008; req_off = 32'h10;
      @(negedge clk);
      req_prot = 1'b0; req_seg = 16'h1111; req_off = 32'h1;
      chk("R9 ready low", {31'h0, req_ready}, 32'd0);
      @(negedge clk);
      chk("R9 ignored request no done", {31'h0, done}, 32'd0);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R9 ignored request no done", {31'h0, done}, 32'd0);
      @(negedge clk);
      chk("R9 protected result kept", lin_addr, 32'h0001_A010);
      chk("R10 done high", {31'h0, done}, 32'd1);
      @(negedge clk);
      chk("R10 done single pulse", {31'h0, done}, 32'd0);
      chk("R9 no second result", lin_addr, 32'h0001_A010);

      // R8/R10: fault is a single pulse
      run_req(1'b1, 16'h0010, 32'h0000_0200, 1'b1, 32'h0);
      @(negedge clk);
      chk("R10 fault single pulse", {31'h0, fault}, 32'd0);

      // R1: reset mid-fetch
      req_valid = 1'b1; req_prot = 1'b1; req_seg = 16'h0018; req_off = 32'h5;
      @(negedge clk);
      req_valid = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk("R1 reset mid-fetch ready", {31'h0, req_ready}, 32'd1);
      chk("R1 reset mid-fetch rd_en", {31'h0, mem_rd_en}, 32'd0);
      repeat (3) begin
         @(negedge clk);
         chk("R1 no result after reset", {31'h0, done | fault}, 32'd0);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule